// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block runs whole word transactions on a three-wire serial EEPROM (chip select, serial clock, data out, data in). A host presents one command: an operation code, a word address and write data. The block then produces every bit frame, clock edge and deselect gap the device needs, without further software help. A read returns one data word. A write runs the full protected sequence: unlock, program, wait until the device reports ready, lock again. A done pulse marks the end of each command.

All serial timing derives from one programmable period of `cfg_div + 1` system clock cycles. Each phase of the serial protocol (data setup, clock high, clock low, deselect gap, one ready poll) lasts exactly one period. The divider value and the poll limit are captured when a command is accepted. The ready wait after programming is bounded. When the bound runs out, a timeout flag is raised and the sequence still finishes with the lock frame, so the device is never left unlocked.

Top module: `mw_eeprom_master`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0, and `busy` reads 1 after that edge. `cmd_op` codes: 0 = read word, 1 = write word, 2 = unlock (write enable), 3 = lock (write disable).
- R2: A read sends an 11-bit frame, first bit first: a 1, the wire opcode bits 1 then 0, then the 8 address bits from bit 7 down to bit 0. Sixteen more serial clocks follow, and `rdata` holds the word received, first received bit in bit 15.
- R3: A program frame has 27 bits, sent first bit first: a 1, the wire opcode bits 0 then 1, the 8 address bits from bit 7 down, then the 16 data bits from bit 15 down.
- R4: The unlock frame is a 1, two 0 bits and then eight 1 bits. The lock frame is a 1 followed by ten 0 bits. Each ends with a deselect.
- R5: Each sent bit takes three periods with chip select high: data placed with clock low, clock high, clock low. A period is `cfg_div + 1` cycles, using the value captured at acceptance.
- R6: Each received bit takes two periods: clock high, with data in sampled at the end of that period, then clock low.
- R7: Chip select is low for exactly one period after every frame and after the ready wait. A read lasts 66 periods and a single unlock or lock lasts 34 periods, counted from the accepting edge to the edge that raises `done`.
- R8: A write command runs, in order: unlock frame, program frame, ready wait, lock frame. It lasts 151 + n periods, where n is the number of ready samples taken.
- R9: During the ready wait, chip select is high and the serial clock is low. Data in is sampled once per period, and the first sample that reads 1 ends the wait.
- R10: The ready wait takes at most max(`cfg_poll_limit`, 1) samples. If none of them reads 1, `timeout` is set and the lock frame still follows. `timeout` stays set until the next accepted command clears it.
- R11: `done` is high for exactly one cycle, right after the final deselect period, and `busy` is 0 in that same cycle.
- R12: `cmd_valid` while `busy` is 1 has no effect: the running command keeps its length and its results, and no second command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code (see R1) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to program |
| cfg_div | input | DIV_W | Period length minus one, in clock cycles |
| cfg_poll_limit | input | POLL_W | Maximum number of ready samples |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle end-of-command pulse |
| timeout | output | 1 | Ready wait of the last write ran out |
| rdata | output | DATA_W | Last word read |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_do | output | 1 | Serial data to the device |
| ee_di | input | 1 | Serial data from the device |

## Verification
The bench builds the block with a 2-bit divider field and a 4-bit poll limit. This makes every period length from one to four cycles and every poll limit, including zero and the maximum of fifteen, reachable in a short run. With the one-cycle period, every one of the 256 addresses is programmed and read back through a behavioural device model that rejects malformed frames. Ready delays are chosen so that the wait ends on the first sample, on the last permitted sample, or one sample too late. The longer periods are checked on a handful of addresses, and the divider input is changed during each command to confirm that the value captured at acceptance is the one used.

// File: rtl/mw_pkg.sv
package mw_pkg;

   // host-side operation codes
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_WREN  = 2'd2,
      OP_WRDIS = 2'd3
   } mw_op_e;

   // sequencer states
   typedef enum logic [2:0] {
      S_IDLE,
      S_SHIFT,
      S_RECV,
      S_GAP,
      S_POLL
   } mw_state_e;

   // opcode bits carried on the wire after the start bit
   localparam logic [1:0] WIRE_READ  = 2'b10;
   localparam logic [1:0] WIRE_PROG  = 2'b01;
   localparam logic [1:0] WIRE_EXTD  = 2'b00;

endpackage

// File: rtl/mw_period_timer.sv
module mw_period_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("mw_period_timer: DIV_W must be at least 1");
      end
   endgenerate

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (start) begin
         div_q <= div_in;
         cnt_q <= div_in;
      end else if (run) begin
         if (cnt_q == '0) cnt_q <= div_q;
         else             cnt_q <= cnt_q - ONE;
      end
   end

   assign tick = run && (cnt_q == '0);

   // the countdown never leaves the window set by the captured divider
   assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= div_q);

endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
   parameter int FRM_W  = 27,
   parameter int DATA_W = 16,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FRM_W-1:0]  frame,
   input  logic [LEN_W-1:0]  len,
   input  logic              tx_adv,
   input  logic              rx_start,
   input  logic              rx_take,
   input  logic              rx_adv,
   input  logic              di,
   output logic              tx_bit,
   output logic              last,
   output logic [DATA_W-1:0] rx_word
);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("mw_shifter: DATA_W must be at least 2");
      end
      if (FRM_W < DATA_W + 3) begin : g_bad_frame
         $error("mw_shifter: FRM_W too small for the data field");
      end
   endgenerate

   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
   localparam logic [LEN_W-1:0] RX_BITS = LEN_W'(DATA_W);

   logic [FRM_W-1:0]  tx_q;
   logic [LEN_W-1:0]  left_q;
   logic [DATA_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         tx_q   <= frame;
         left_q <= len;
      end else if (rx_start) begin
         left_q <= RX_BITS;
      end else if (tx_adv) begin
         tx_q   <= {tx_q[FRM_W-2:0], 1'b0};
         left_q <= left_q - ONE;
      end else if (rx_adv) begin
         left_q <= left_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rx_q <= '0;
      else if (rx_take) rx_q <= {rx_q[DATA_W-2:0], di};
   end

   assign tx_bit  = tx_q[FRM_W-1];
   assign last    = (left_q == ONE);
   assign rx_word = rx_q;

   // the sequencer never steps past the final bit of a frame
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_adv || rx_adv) |-> (left_q > ONE));

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
   import mw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int DIV_W  = 8,
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [POLL_W-1:0] cfg_poll_limit,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic [DATA_W-1:0] rdata,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_do,
   input  logic              ee_di
);

   localparam int CMD_LEN = 3 + ADDR_W;
   localparam int FRM_W   = CMD_LEN + DATA_W;
   localparam int LEN_W   = $clog2(FRM_W + 1);

   localparam logic [LEN_W-1:0]  LEN_CMD  = LEN_W'(CMD_LEN);
   localparam logic [LEN_W-1:0]  LEN_PROG = LEN_W'(FRM_W);
   localparam logic [POLL_W:0]   P_ONE    = (POLL_W+1)'(1);
   localparam logic [POLL_W-1:0] P_INC    = POLL_W'(1);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("mw_eeprom_master: ADDR_W must be at least 1");
      end
      if (POLL_W < 1) begin : g_bad_poll
         $error("mw_eeprom_master: POLL_W must be at least 1");
      end
   endgenerate

   function automatic logic [FRM_W-1:0] mk_frame(
      input logic [1:0]        w,
      input logic [ADDR_W-1:0] a,
      input logic [DATA_W-1:0] d);
      return {1'b1, w, a, d};
   endfunction

   mw_state_e         state_q;
   logic [1:0]        ph_q;
   logic [1:0]        seq_q;
   mw_op_e            op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [POLL_W-1:0] limit_q;
   logic [POLL_W-1:0] poll_q;
   logic              tmo_q;
   logic              done_q;

   logic              tick;
   logic              tx_bit;
   logic              last;
   logic [DATA_W-1:0] rx_word;

   logic              accept;
   logic              is_write;
   logic              gap_go;
   logic              ld;
   logic [FRM_W-1:0]  frm;
   logic [LEN_W-1:0]  ln;
   logic              tx_adv;
   logic              rx_start;
   logic              rx_take;
   logic              rx_adv;
   logic              poll_out;

   assign accept   = cmd_valid && (state_q == S_IDLE);
   assign is_write = (op_q == OP_WRITE);
   assign gap_go   = tick && (state_q == S_GAP);
   assign poll_out = (({1'b0, poll_q} + P_ONE) >= {1'b0, limit_q});

   // frame selection: a write starts with the unlock frame
   always_comb begin
      ld  = 1'b0;
      frm = '0;
      ln  = LEN_CMD;
      if (accept) begin
         ld = 1'b1;
         case (mw_op_e'(cmd_op))
            OP_READ:  frm = mk_frame(WIRE_READ, cmd_addr, '0);
            OP_WRDIS: frm = mk_frame(WIRE_EXTD, '0, '0);
            default:  frm = mk_frame(WIRE_EXTD, '1, '0);
         endcase
      end else if (gap_go && is_write && (seq_q == 2'd0)) begin
         ld  = 1'b1;
         frm = mk_frame(WIRE_PROG, addr_q, wdata_q);
         ln  = LEN_PROG;
      end else if (gap_go && is_write && (seq_q == 2'd2)) begin
         ld  = 1'b1;
         frm = mk_frame(WIRE_EXTD, '0, '0);
      end
   end

   assign tx_adv   = tick && (state_q == S_SHIFT) && (ph_q == 2'd2) && !last;
   assign rx_start = tick && (state_q == S_SHIFT) && (ph_q == 2'd2) && last
                     && (op_q == OP_READ);
   assign rx_take  = tick && (state_q == S_RECV) && (ph_q == 2'd0);
   assign rx_adv   = tick && (state_q == S_RECV) && (ph_q == 2'd1) && !last;

   mw_period_timer #(.DIV_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .run    (busy),
      .div_in (cfg_div),
      .tick   (tick)
   );

   mw_shifter #(.FRM_W(FRM_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .frame    (frm),
      .len      (ln),
      .tx_adv   (tx_adv),
      .rx_start (rx_start),
      .rx_take  (rx_take),
      .rx_adv   (rx_adv),
      .di       (ee_di),
      .tx_bit   (tx_bit),
      .last     (last),
      .rx_word  (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         ph_q    <= 2'd0;
         seq_q   <= 2'd0;
         op_q    <= OP_READ;
         addr_q  <= '0;
         wdata_q <= '0;
         limit_q <= '0;
         poll_q  <= '0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (accept) begin
                  state_q <= S_SHIFT;
                  ph_q    <= 2'd0;
                  seq_q   <= 2'd0;
                  op_q    <= mw_op_e'(cmd_op);
                  addr_q  <= cmd_addr;
                  wdata_q <= cmd_wdata;
                  limit_q <= cfg_poll_limit;
                  tmo_q   <= 1'b0;
               end
            end
            S_SHIFT: begin
               if (tick) begin
                  if (ph_q != 2'd2) begin
                     ph_q <= ph_q + 2'd1;
                  end else if (!last) begin
                     ph_q <= 2'd0;
                  end else if (op_q == OP_READ) begin
                     state_q <= S_RECV;
                     ph_q    <= 2'd0;
                  end else begin
                     state_q <= S_GAP;
                  end
               end
            end
            S_RECV: begin
               if (tick) begin
                  if (ph_q == 2'd0) ph_q <= 2'd1;
                  else if (!last)   ph_q <= 2'd0;
                  else              state_q <= S_GAP;
               end
            end
            S_GAP: begin
               if (tick) begin
                  seq_q <= seq_q + 2'd1;
                  if (is_write && (seq_q != 2'd3)) begin
                     if (seq_q == 2'd1) begin
                        state_q <= S_POLL;
                        poll_q  <= '0;
                     end else begin
                        state_q <= S_SHIFT;
                        ph_q    <= 2'd0;
                     end
                  end else begin
                     state_q <= S_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            S_POLL: begin
               if (tick) begin
                  if (ee_di) begin
                     state_q <= S_GAP;
                  end else if (poll_out) begin
                     tmo_q   <= 1'b1;
                     state_q <= S_GAP;
                  end else begin
                     poll_q <= poll_q + P_INC;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != S_IDLE);
   assign done    = done_q;
   assign timeout = tmo_q;
   assign rdata   = rx_word;
   assign ee_cs   = (state_q == S_SHIFT) || (state_q == S_RECV) || (state_q == S_POLL);
   assign ee_sk   = ((state_q == S_SHIFT) && (ph_q == 2'd1)) ||
                    ((state_q == S_RECV)  && (ph_q == 2'd0));
   assign ee_do   = (state_q == S_SHIFT) && tx_bit;

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_ignore_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q)));

   assert_timeout_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> (op_q == OP_WRITE));

   assert_poll_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_POLL) |-> ((poll_q == '0) || (poll_q < limit_q)));

   assert_poll_quiet_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_POLL) |-> (ee_cs && !ee_sk));

endmodule

// File: tb/test_mw_eeprom_master.sv
`timescale 1ns/1ps
module test_mw_eeprom_master;

   localparam int AW = 8;
   localparam int DW = 16;
   localparam int DIVW = 2;
   localparam int PW = 4;
   localparam logic [1:0] C_RD = 2'd0, C_WR = 2'd1, C_EN = 2'd2, C_DIS = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic           cmd_valid = 1'b0;
   logic [1:0]     cmd_op = '0;
   logic [AW-1:0]  cmd_addr = '0;
   logic [DW-1:0]  cmd_wdata = '0;
   logic [DIVW-1:0] cfg_div = '0;
   logic [PW-1:0]  cfg_poll_limit = '0;
   logic busy, done, timeout, ee_cs, ee_sk, ee_do, ee_di;
   logic [DW-1:0]  rdata;

   int checks = 0;
   int errors = 0;

   // behavioural device model
   logic [15:0] mem [256];
   int          mcnt = 0;
   logic [26:0] mcmd = '0;
   logic        wen = 1'b0;
   logic        pollmode = 1'b0;
   logic        rd_bit = 1'b0;
   logic        rd_read = 1'b0;
   logic [7:0]  raddr = '0;
   int          pc = 0;
   int          ready_r = 0;
   int          frame_err = 0;
   int          cur_p = 1;
   int          skhi = 0;
   int          sk_err = 0;

   assign ee_di = (pollmode && ee_cs) ? (pc >= ready_r) : rd_bit;

   mw_eeprom_master #(.ADDR_W(AW), .DATA_W(DW), .DIV_W(DIVW), .POLL_W(PW)) i_mw_eeprom_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cfg_div(cfg_div),
      .cfg_poll_limit(cfg_poll_limit), .busy(busy), .done(done), .timeout(timeout),
      .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di));

   always @(posedge ee_sk) begin
      if (ee_cs) begin
         mcnt++;
         if (mcnt <= 27) mcmd = {mcmd[25:0], ee_do};
         if (mcnt == 11 && mcmd[10:8] == 3'b110) begin
            rd_read = 1'b1;
            raddr = mcmd[7:0];
         end
         if (rd_read && mcnt >= 12 && mcnt <= 27) rd_bit = mem[raddr][27-mcnt];
      end
   end

   always @(negedge ee_cs) begin
      if (rst_n) begin
         if (mcnt == 0) begin
            if (pollmode) pollmode = 1'b0;
            else frame_err++;
         end else if (mcnt == 11) begin
            if (mcmd[10:8] == 3'b100 && mcmd[7:0] == 8'hFF) wen = 1'b1;
            else if (mcmd[10:8] == 3'b100 && mcmd[7:0] == 8'h00) wen = 1'b0;
            else frame_err++;
         end else if (mcnt == 27) begin
            if (rd_read) begin
            end else if (mcmd[26:24] == 3'b101 && wen) begin
               mem[mcmd[23:16]] = mcmd[15:0];
               pollmode = 1'b1;
            end else frame_err++;
         end else frame_err++;
      end
      mcnt = 0;
      rd_bit = 1'b0;
      rd_read = 1'b0;
   end

   always @(posedge clk) begin
      if (ee_cs && pollmode) pc <= pc + 1;
      else pc <= 0;
   end

   // serial clock high time must be one period (R5)
   always @(posedge clk) begin
      if (rst_n) begin
         if (ee_sk) skhi++;
         else if (skhi != 0) begin
            if (skhi != cur_p) sk_err++;
            skhi = 0;
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int a, input int salt);
      return 16'((a * 16'h0101) ^ 16'h5A3C ^ (salt * 16'h1111));
   endfunction

   task automatic run_op(input logic [1:0] op, input int a, input logic [15:0] d,
                         input int div, input int lim, input bit inject, output int cyc);
      @(negedge clk);
      cur_p = div + 1;
      cmd_op = op; cmd_addr = AW'(a); cmd_wdata = d;
      cfg_div = DIVW'(div); cfg_poll_limit = PW'(lim);
      cmd_valid = 1'b1;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      cfg_div = ~DIVW'(div);
      if (!busy) begin
         checks++; errors++;
         $display("FAIL R1: busy actual 0 expected 1");
      end
      cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         if (done) break;
         if (inject && cyc == 5) begin
            cmd_valid = 1'b1; cmd_op = C_RD; cmd_addr = ~AW'(a);
         end else cmd_valid = 1'b0;
         if (cyc > 40000) break;
      end
      cmd_valid = 1'b0;
      if (busy) begin
         checks++; errors++;
         $display("FAIL R11: busy with done actual 1 expected 0");
      end
   endtask

   function automatic int polls(input int r, input int p, input int lim);
      int k = (r + p) / p;
      int m = (lim < 1) ? 1 : lim;
      return (k < m) ? k : m;
   endfunction

   task automatic do_write(input int a, input logic [15:0] d, input int div,
                           input int lim, input int r, input string tag);
      int cyc;
      int p = div + 1;
      int m = (lim < 1) ? 1 : lim;
      ready_r = r;
      run_op(C_WR, a, d, div, lim, 1'b0, cyc);
      chk({tag, " R8 write length"}, cyc, (151 + polls(r, p, lim)) * p);
      chk({tag, " R10 timeout"}, timeout, ((r + p) / p > m) ? 1 : 0);
      chk({tag, " R3 stored word"}, mem[a], d);
      chk({tag, " R8 relocked"}, wen, 0);
   endtask

   task automatic do_read(input int a, input logic [15:0] exp, input int div, input string tag);
      int cyc;
      run_op(C_RD, a, 16'h0, div, 15, 1'b0, cyc);
      chk({tag, " R7 read length"}, cyc, 66 * (div + 1));
      chk({tag, " R2 R6 read data"}, rdata, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      logic [15:0] keep;
      bit stayed;
      repeat (4) @(posedge clk);
      #1;
      chk("R1 reset busy", busy, 0);
      chk("R11 reset done", done, 0);
      chk("R10 reset timeout", timeout, 0);
      chk("R5 reset cs", ee_cs, 0);
      chk("R5 reset sk", ee_sk, 0);
      @(negedge clk) rst_n = 1'b1;

      // R4: unlock and lock frames
      run_op(C_EN, 0, 16'h0, 0, 15, 1'b0, cyc);
      chk("R4 R7 unlock length", cyc, 34);
      chk("R4 unlock state", wen, 1);
      run_op(C_DIS, 0, 16'h0, 1, 15, 1'b0, cyc);
      chk("R4 R7 lock length", cyc, 68);
      chk("R4 lock state", wen, 0);

      // exhaustive address sweep with one-cycle period
      for (int a = 0; a < 256; a++) do_write(a, pat(a, 0), 0, 15, a % 7, "sweep");
      for (int a = 0; a < 256; a++) do_read(a, pat(a, 0), 0, "sweep");

      // longer periods on selected addresses
      for (int dv = 1; dv < 4; dv++) begin
         for (int i = 0; i < 6; i++) begin
            int a = (i * 8'h55 + dv * 8'h13) & 8'hFF;
            do_write(a, pat(a, dv), dv, 15, 5 + i, "div");
            do_read(a, pat(a, dv), dv, "div");
         end
      end

      // ready wait boundaries (R9 R10)
      do_write(7, 16'h1234, 0, 3, 2, "ready on last sample");
      do_write(8, 16'h4321, 0, 3, 3, "one sample late");
      repeat (5) @(posedge clk);
      #1 chk("R10 timeout held", timeout, 1);
      do_write(9, 16'hBEEF, 0, 0, 100000, "limit zero");
      do_write(10, 16'hCAFE, 2, 15, 100000, "limit max");
      do_read(10, 16'hCAFE, 0, "after timeout");
      chk("R10 timeout cleared", timeout, 0);

      // R12: strobe while busy
      keep = rdata;
      ready_r = 0;
      run_op(C_WR, 20, 16'h0F0F, 0, 15, 1'b1, cyc);
      chk("R12 length unchanged", cyc, 152);
      chk("R12 word stored", mem[20], 16'h0F0F);
      chk("R12 rdata untouched", rdata, keep);
      stayed = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #1;
         if (busy || done) stayed = 1'b0;
      end
      chk("R12 no queued command", stayed, 1);

      chk("R2 R3 R4 frame errors", frame_err, 0);
      chk("R5 clock high width", sk_err, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule